// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a recovery watchdog for a small 8-bit controller. It listens to the controller's special-function-register write port and to the machine-cycle enable pulse. It stays idle after every reset. It is armed only when software writes a two-byte key, 0x1E followed by 0xE1, to the key register at address 0xA6. Once armed, it counts machine cycles in a 14-bit counter. Writing the same key again clears the count. Nothing except a reset can disarm it.

If software fails to refresh the counter before it reaches its terminal value, the block raises an active-high reset pulse. The pulse has a fixed length in oscillator clocks, and the clock-mode input chooses that length. The pulse also acts as a synchronous reset of the watchdog itself. The key register is write-only. Neither the counter nor the arm state can be read or written directly.

Top module: `kwdt_top`

## Requirements
- R1: After the external reset `rst`, the watchdog is disarmed, its count is zero and `wdt_rst_o` is low.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to address 0xA6, arms the watchdog and starts the count at zero.
- R3: A write of 0xE1 to 0xA6 completes the key only if the previous write to 0xA6 was 0x1E. Any other value written to 0xA6 discards a half-entered key, so the order 0xE1 then 0x1E does not arm the block.
- R4: Writes to any address other than 0xA6 neither advance nor discard a half-entered key.
- R5: While armed, the count rises by one on each clock with `cyc_en` high.
- R6: While armed, a complete key clears the count to zero, and the refresh takes priority over that cycle's increment.
- R7: Once armed, the block stays armed until a reset. Stray values written to 0xA6 do not disarm it.
- R8: On the 16383rd counted machine cycle after arming or the last refresh, the count reaches 0x3FFF and `wdt_rst_o` goes high on the next clock. It stays low through cycle 16382.
- R9: The pulse lasts exactly 98 `clk` cycles when `clk_mode` is 0 (6-clock mode) and 196 when `clk_mode` is 1 (12-clock mode). The mode is sampled at overflow, and the pulse length does not depend on `cyc_en`.
- R10: While the pulse is high, key writes are ignored. After the pulse, the watchdog is disarmed with a zero count and produces no further pulse until it is armed again.
- R11: An external reset while armed disarms the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high external reset |
| cyc_en | input | 1 | One-clock machine-cycle enable |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| clk_mode | input | 1 | 0 selects 6-clock mode, 1 selects 12-clock mode |
| wdt_rst_o | output | 1 | Registered active-high reset pulse |

## Verification
The hardest state to reach from the ports is the edge of overflow. The counter must sit exactly one machine cycle short of 0x3FFF, having followed a key that was interleaved with foreign-address writes and stray key-register values. The bench reaches it by holding `cyc_en` high for a computed run of 16382 clocks after the arming write, checks that the output is still low, and then issues one more enable. The same arithmetic, shifted by a refresh in mid-run, shows that servicing restarts the full window.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic {
    KS_IDLE = 1'b0,
    KS_HALF = 1'b1
  } key_state_e;

  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic              key_ok
);
  key_state_e state_q;
  logic       hit;

  assign hit    = sfr_we && (sfr_addr == KEY_ADDR);
  assign key_ok = !clr && hit && (state_q == KS_HALF) && (sfr_wdata == KEY_SECOND);

  // Only writes to the key address move the tracker; any non-first value drops it.
  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= KS_IDLE;
    end else if (hit) begin
      state_q <= (sfr_wdata == KEY_FIRST) ? KS_HALF : KS_IDLE;
    end
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             key_ok,
  input  logic             cyc_en,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  localparam logic [CNT_W-1:0] LAST     = '1;
  localparam logic [CNT_W-1:0] PRE_LAST = LAST - 1'b1;

  logic at_edge;

  assign at_edge = (cnt == PRE_LAST);
  assign fire    = armed && cyc_en && !key_ok && at_edge;

  always_ff @(posedge clk) begin
    if (clr) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (key_ok) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && cyc_en) begin
      if (at_edge) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch
  import kwdt_pkg::*;
#(
  parameter int FAST_LEN = 98,
  parameter int SLOW_LEN = 196
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic slow_mode,
  output logic pulse_o
);
  localparam int MAX_LEN = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] FAST_LOAD = LEN_W'(FAST_LEN - 1);
  localparam logic [LEN_W-1:0] SLOW_LOAD = LEN_W'(SLOW_LEN - 1);

  clk_mode_e        mode;
  logic [LEN_W-1:0] left_q;

  assign mode = clk_mode_e'(slow_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (pulse_o) begin
      if (left_q == '0) begin
        pulse_o <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end else if (fire) begin
      pulse_o <= 1'b1;
      left_q  <= (mode == MODE_SLOW) ? SLOW_LOAD : FAST_LOAD;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int CNT_W    = 14,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
  parameter int FAST_LEN = 98,
  parameter int SLOW_LEN = 196
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              clk_mode,
  output logic              wdt_rst_o
);
  logic             clr;
  logic             key_ok;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             fire;

  // The pulse itself holds the watchdog in reset.
  assign clr = rst || wdt_rst_o;

  kwdt_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .clr(clr), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .key_ok(key_ok)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(clr), .key_ok(key_ok), .cyc_en(cyc_en),
    .armed(armed), .cnt(cnt), .fire(fire)
  );

  kwdt_stretch #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .slow_mode(clk_mode), .pulse_o(wdt_rst_o)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int CNT_W    = 14,
  parameter int FAST_LEN = 98,
  parameter int SLOW_LEN = 196
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             key_ok,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             clk_mode,
  input logic             rst_o
);
  localparam logic [CNT_W-1:0] PRE_LAST = {CNT_W{1'b1}} - 1'b1;

  int   plen;
  logic mode_q;
  logic seen_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      plen     <= 0;
      mode_q   <= 1'b0;
      seen_low <= 1'b0;
    end else if (rst_o) begin
      plen <= plen + 1;
    end else begin
      plen     <= 0;
      mode_q   <= clk_mode;
      seen_low <= 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rst_o && !armed && cnt == '0));

  a_r6_refresh_clears: assert property (@(posedge clk) disable iff (rst)
    key_ok |=> (cnt == '0 && armed));

  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (armed && cyc_en && !key_ok && !rst_o && cnt != PRE_LAST) |=> (cnt == $past(cnt) + 1'b1));

  a_r7_stays_armed: assert property (@(posedge clk) disable iff (rst)
    armed |=> (armed || rst_o));

  a_r8_overflow_fires: assert property (@(posedge clk) disable iff (rst)
    (armed && cyc_en && !key_ok && cnt == PRE_LAST) |=> rst_o);

  a_r10_held_in_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_o |=> (!armed && cnt == '0));

  a_r9_pulse_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_o) && seen_low) |-> (plen == (mode_q ? SLOW_LEN : FAST_LEN)));
endmodule

bind kwdt_top kwdt_checker #(
  .CNT_W(CNT_W), .FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .key_ok(key_ok), .armed(armed),
  .cnt(cnt), .clk_mode(clk_mode), .rst_o(wdt_rst_o)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 16383;
  localparam int QUIET      = 16400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       clk_mode = 1'b0;
  logic       wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int hi_cycles = 0;

  kwdt_top dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .clk_mode(clk_mode), .wdt_rst_o(wdt_rst_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge wdt_rst_o) rises++;
  always @(negedge clk) if (wdt_rst_o === 1'b1) hi_cycles++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cyc_en = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic wait_pulse_end();
    for (int i = 0; i < 1000 && wdt_rst_o; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wdt_rst_o == 1'b0, "R1 reset output low", int'(wdt_rst_o), 0);

    // Wrong order, then a key broken by a stray value at the key address.
    wr(8'hA6, 8'hE1); wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    tick(QUIET);
    check(rises == 0, "R3 bad key order leaves block idle", rises, 0);

    // Key with foreign-address writes in between must still arm.
    wr(8'hA6, 8'h1E); wr(8'hA5, 8'hE1); wr(8'h00, 8'h1E); wr(8'hA6, 8'hE1);
    tick(8000);
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);  // stray values: R7, no refresh
    tick(WINDOW - 1 - 8000);
    check(wdt_rst_o == 1'b0, "R8 low at cycle 16382", int'(wdt_rst_o), 0);
    check(rises == 0, "R4 no early pulse", rises, 0);
    hi_cycles = 0;
    tick(1);
    check(wdt_rst_o == 1'b1, "R8 high after cycle 16383 (R2 R4 R7)", int'(wdt_rst_o), 1);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);  // ignored during pulse
    wait_pulse_end();
    check(hi_cycles == 98, "R9 fast-mode pulse length", hi_cycles, 98);
    check(wdt_rst_o == 1'b0, "R10 pulse ended", int'(wdt_rst_o), 0);
    tick(QUIET);
    check(rises == 1, "R10 disarmed after pulse", rises, 1);

    // Refresh in 12-clock mode.
    clk_mode = 1'b1;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    tick(16000);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    tick(WINDOW - 1);
    check(wdt_rst_o == 1'b0, "R6 refresh restarts window", int'(wdt_rst_o), 0);
    check(rises == 1, "R6 no pulse while serviced", rises, 1);
    hi_cycles = 0;
    tick(1);
    check(wdt_rst_o == 1'b1, "R5 exact count to overflow", int'(wdt_rst_o), 1);
    wait_pulse_end();
    check(hi_cycles == 196, "R9 slow-mode pulse length", hi_cycles, 196);

    // External reset disarms.
    clk_mode = 1'b0;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    tick(5000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(wdt_rst_o == 1'b0, "R11 output low after reset", int'(wdt_rst_o), 0);
    base = rises;
    tick(QUIET);
    check(rises == base, "R11 reset disarms", rises, base);

    // Arming after reset again times out exactly.
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    tick(WINDOW);
    check(wdt_rst_o == 1'b1, "R2 rearm after reset", int'(wdt_rst_o), 1);
    wait_pulse_end();
    report();
  end
endmodule